// File: doc/BRIEF.md
# Paged DMA Translation Unit

This block turns device DMA addresses into host physical addresses. It holds a table of translation entries on chip. Each entry covers one I/O page, whose size is a programmable power of two. A window is described by a base offset, a page shift and an entry count. A request offers one address and gets back four values one cycle later: the page-aligned I/O address, the translated address, the in-page offset mask and the access permission. An address outside the window does not raise a fault. It gets a fixed "no translation" answer: zero addresses, an all-ones mask and no permission.

The window is opened with an enable pulse and closed with a disable pulse. A separate write port lets an external update engine fill entries one at a time. A clear sweep sets every entry to zero, which makes every page fault. The sweep runs after reset and again on request.

Requests and responses both use valid/ready handshakes:
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is low while the clear sweep runs, and low while a response is waiting and `rsp_ready` is low.
- A requester should hold its address until the request is taken.
- A response stays on the outputs, unchanged, until it is taken with `rsp_ready`.

The window and table pins are plain control pins with no handshake.

Parameter rule: `2**SHIFT_W` must not exceed `ADDR_W`, and `ENTRY_W` must be at least `ADDR_W`.

Top module: `dma_xlate_unit`

## Requirements
- R1: For an in-window access, the permission is bits [1:0] of the entry: 0 means none (fault), 1 read-only, 2 write-only, 3 read-write.
- R2: For an in-window access, with page size `2**shift`:
  - `rsp_mask` is page size minus one.
  - `rsp_iova` is `(addr - base)` with the mask bits cleared.
  - `rsp_paddr` is the low `ADDR_W` bits of the entry with the mask bits cleared.
- R3: An access is in the window only when the entry count is nonzero and `((addr - base) mod 2**ADDR_W) >> shift` is below the entry count. That shifted value is the entry index.
- R4: An access outside the window returns `rsp_iova` = 0, `rsp_paddr` = 0, an all-ones `rsp_mask` and permission 0. This includes any request made while the window is disabled.
- R5: An enable pulse with a nonzero `cfg_count` on a disabled window loads base, shift and count, with the count clamped to `MAX_ENTRIES`. An enable on an already open window is ignored, and so is an enable with count 0.
- R6: A disable pulse sets base, shift and count to zero and closes the window. A disable takes priority over an enable in the same cycle.
- R7: `win_on` is high when the count is nonzero, `win_base` shows the base, and `win_size` equals count shifted left by shift.
- R8: A request taken on edge k produces `rsp_valid` high after edge k. The configuration and table contents it uses are those in effect before edge k. An entry update on the same edge is not seen by that request.
- R9: `req_ready` is `!sweep && (!rsp_valid || rsp_ready)`. A response waiting with `rsp_ready` low keeps all of its output fields stable.
- R10: After reset, and after a `tbl_clear` pulse while no sweep is running, a sweep writes zero to one entry per cycle for `MAX_ENTRIES` cycles. During the sweep, `req_ready` is low, `upd_valid` writes are dropped and `tbl_clear` is ignored.
- R11: When no sweep is running, `upd_valid` writes `upd_data` into entry `upd_idx`. An index of `MAX_ENTRIES` or more is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Pulse: open the window with the cfg_* values |
| cfg_disable | input | 1 | Pulse: close the window and zero its settings |
| cfg_base | input | ADDR_W | Window base offset |
| cfg_shift | input | SHIFT_W | Page shift |
| cfg_count | input | CNT_W | Entry count |
| win_on | output | 1 | Window open |
| win_base | output | ADDR_W | Current base offset |
| win_size | output | ADDR_W+CNT_W | Current window size in bytes |
| tbl_clear | input | 1 | Pulse: start a clear sweep |
| upd_valid | input | 1 | Entry write strobe |
| upd_idx | input | IDX_W | Entry write index |
| upd_data | input | ENTRY_W | Entry write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | ADDR_W | Device DMA address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_iova | output | ADDR_W | Page-aligned window-relative I/O address |
| rsp_paddr | output | ADDR_W | Translated page address |
| rsp_mask | output | ADDR_W | In-page offset mask |
| rsp_perm | output | 2 | Permission code |

## Verification
The bench builds the unit with a 16-bit address, a 4-bit shift and 12 entries. Because 12 is not a power of two, update indices 12 to 15 exist on the port and can be checked as dropped. The same choice makes a count request of 15 exercise the clamp. A shift of 15 pushes the page mask to its widest, and a base of 0xFFFE makes the window-relative address wrap. With these sizes the clear sweep finishes in a few cycles, so it can be repeated, overlapped by a second clear and run against blocked updates within a short run.

// File: rtl/dxu_pkg.sv
package dxu_pkg;
  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_RO   = 2'd1,
    PERM_WO   = 2'd2,
    PERM_RW   = 2'd3
  } perm_e;
endpackage

// File: rtl/dxu_window.sv
module dxu_window #(
  parameter int ADDR_W      = 64,
  parameter int SHIFT_W     = 6,
  parameter int CNT_W       = 7,
  parameter int MAX_ENTRIES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               dis_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [CNT_W-1:0]   count_i,
  output logic [ADDR_W-1:0]  base_o,
  output logic [SHIFT_W-1:0] shift_o,
  output logic [CNT_W-1:0]   count_o
);
  logic [CNT_W-1:0] cnt_lim;

  // Clamp only when the count field can exceed the table depth
  if ((2 ** CNT_W) - 1 > MAX_ENTRIES) begin : g_clamp
    assign cnt_lim = (count_i > CNT_W'(MAX_ENTRIES)) ? CNT_W'(MAX_ENTRIES) : count_i;
  end else begin : g_pass
    assign cnt_lim = count_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_o  <= '0;
      shift_o <= '0;
      count_o <= '0;
    end else if (dis_i) begin
      base_o  <= '0;
      shift_o <= '0;
      count_o <= '0;
    end else if (en_i && (count_o == '0) && (count_i != '0)) begin
      base_o  <= base_i;
      shift_o <= shift_i;
      count_o <= cnt_lim;
    end
  end
endmodule

// File: rtl/dxu_lookup.sv
module dxu_lookup #(
  parameter int ADDR_W  = 64,
  parameter int SHIFT_W = 6,
  parameter int CNT_W   = 7,
  parameter int IDX_W   = 6
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [CNT_W-1:0]   count_i,
  output logic               inb_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [ADDR_W-1:0]  iova_o,
  output logic [ADDR_W-1:0]  pmask_o
);
  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] idx_full;

  always_comb begin
    rel      = addr_i - base_i;
    idx_full = rel >> shift_i;
    inb_o    = (count_i != '0) && (idx_full < ADDR_W'(count_i));
    pmask_o  = {ADDR_W{1'b1}} << shift_i;
    iova_o   = rel & pmask_o;
    idx_o    = idx_full[IDX_W-1:0];
  end
endmodule

// File: rtl/dxu_table.sv
module dxu_table #(
  parameter int ENTRY_W     = 64,
  parameter int MAX_ENTRIES = 64,
  parameter int IDX_W       = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  output logic               busy_o,
  input  logic               upd_valid_i,
  input  logic [IDX_W-1:0]   upd_idx_i,
  input  logic [ENTRY_W-1:0] upd_data_i,
  input  logic               rd_en_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [ENTRY_W-1:0] rd_data_o
);
  localparam logic [IDX_W:0]   DEPTH    = (IDX_W+1)'(MAX_ENTRIES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_ENTRIES - 1);

  logic [ENTRY_W-1:0] mem [MAX_ENTRIES];
  logic [IDX_W-1:0]   ptr;

  // Sweep control: starts out of reset, restarts on a clear pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b1;
      ptr    <= '0;
    end else if (busy_o) begin
      if (ptr == LAST_IDX) begin
        busy_o <= 1'b0;
        ptr    <= '0;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end else if (clr_i) begin
      busy_o <= 1'b1;
    end
  end

  // Single write port shared by sweep and update engine; read is old-data
  always_ff @(posedge clk) begin
    if (busy_o) begin
      mem[ptr] <= '0;
    end else if (upd_valid_i && ({1'b0, upd_idx_i} < DEPTH)) begin
      mem[upd_idx_i] <= upd_data_i;
    end
    if (rd_en_i) begin
      rd_data_o <= mem[rd_idx_i];
    end
  end
endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit
  import dxu_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int ENTRY_W     = 64,
  parameter int SHIFT_W     = 6,
  parameter int MAX_ENTRIES = 64,
  localparam int CNT_W      = $clog2(MAX_ENTRIES + 1),
  localparam int IDX_W      = $clog2(MAX_ENTRIES),
  localparam int SIZE_W     = ADDR_W + CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic               cfg_disable,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic [CNT_W-1:0]   cfg_count,
  output logic               win_on,
  output logic [ADDR_W-1:0]  win_base,
  output logic [SIZE_W-1:0]  win_size,
  input  logic               tbl_clear,
  input  logic               upd_valid,
  input  logic [IDX_W-1:0]   upd_idx,
  input  logic [ENTRY_W-1:0] upd_data,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [ADDR_W-1:0]  rsp_iova,
  output logic [ADDR_W-1:0]  rsp_paddr,
  output logic [ADDR_W-1:0]  rsp_mask,
  output logic [1:0]         rsp_perm
);
  logic [ADDR_W-1:0]  base_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               sweep;
  logic               lk_inb;
  logic [IDX_W-1:0]   lk_idx;
  logic [ADDR_W-1:0]  lk_iova;
  logic [ADDR_W-1:0]  lk_pmask;
  logic [ENTRY_W-1:0] rd_data;
  logic               accept;
  logic               inb_q;
  logic [ADDR_W-1:0]  iova_q;
  logic [ADDR_W-1:0]  pmask_q;
  perm_e              perm_d;

  dxu_window #(
    .ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W), .MAX_ENTRIES(MAX_ENTRIES)
  ) u_window (
    .clk(clk), .rst_n(rst_n), .en_i(cfg_enable), .dis_i(cfg_disable),
    .base_i(cfg_base), .shift_i(cfg_shift), .count_i(cfg_count),
    .base_o(base_q), .shift_o(shift_q), .count_o(cnt_q)
  );

  dxu_lookup #(
    .ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_lookup (
    .addr_i(req_addr), .base_i(base_q), .shift_i(shift_q), .count_i(cnt_q),
    .inb_o(lk_inb), .idx_o(lk_idx), .iova_o(lk_iova), .pmask_o(lk_pmask)
  );

  assign req_ready = !sweep && (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;

  dxu_table #(
    .ENTRY_W(ENTRY_W), .MAX_ENTRIES(MAX_ENTRIES), .IDX_W(IDX_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .clr_i(tbl_clear), .busy_o(sweep),
    .upd_valid_i(upd_valid), .upd_idx_i(upd_idx), .upd_data_i(upd_data),
    .rd_en_i(accept && lk_inb), .rd_idx_i(lk_idx), .rd_data_o(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      inb_q     <= 1'b0;
      iova_q    <= '0;
      pmask_q   <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      inb_q     <= lk_inb;
      iova_q    <= lk_iova;
      pmask_q   <= lk_pmask;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_comb begin
    perm_d    = inb_q ? perm_e'(rd_data[1:0]) : PERM_NONE;
    rsp_perm  = perm_d;
    rsp_iova  = inb_q ? iova_q : '0;
    rsp_paddr = inb_q ? (rd_data[ADDR_W-1:0] & pmask_q) : '0;
    rsp_mask  = inb_q ? ~pmask_q : {ADDR_W{1'b1}};
  end

  assign win_on   = (cnt_q != '0);
  assign win_base = base_q;
  assign win_size = SIZE_W'(cnt_q) << shift_q;
endmodule

// File: rtl/dxu_checks.sv
module dxu_checks #(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 71
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic              cfg_disable,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_iova,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [ADDR_W-1:0] rsp_mask,
  input logic [1:0]        rsp_perm,
  input logic              win_on,
  input logic [ADDR_W-1:0] win_base,
  input logic [SIZE_W-1:0] win_size
);
  AST_PERM_RANGE_SANE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_mask == {ADDR_W{1'b1}}) |-> (rsp_iova == '0) && (rsp_paddr == '0) && (rsp_perm == 2'd0)); // R4
  AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (((rsp_mask + 1'b1) & rsp_mask) == '0)); // R2
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_iova) && $stable(rsp_paddr)
      && $stable(rsp_mask) && $stable(rsp_perm)); // R9
  AST_REENABLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    win_on && cfg_enable && !cfg_disable |=> $stable(win_base) && $stable(win_size)); // R5
  AST_DISABLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_disable |=> !win_on && (win_base == '0) && (win_size == '0)); // R6
endmodule

bind dma_xlate_unit dxu_checks #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_disable(cfg_disable),
  .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_iova(rsp_iova), .rsp_paddr(rsp_paddr),
  .rsp_mask(rsp_mask), .rsp_perm(rsp_perm), .win_on(win_on),
  .win_base(win_base), .win_size(win_size)
);

// File: tb/dma_xlate_unit_test.sv
module dma_xlate_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 16;
  localparam int EW  = 64;
  localparam int SW  = 4;
  localparam int ME  = 12;
  localparam int CW  = 4;
  localparam int IW  = 4;
  localparam int SZW = AW + CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 0, cfg_disable = 0, tbl_clear = 0, upd_valid = 0;
  logic req_valid = 0, rsp_ready = 1;
  logic [AW-1:0] cfg_base = '0, req_addr = '0;
  logic [SW-1:0] cfg_shift = '0;
  logic [CW-1:0] cfg_count = '0;
  logic [IW-1:0] upd_idx = '0;
  logic [EW-1:0] upd_data = '0;
  logic win_on, req_ready, rsp_valid;
  logic [AW-1:0] win_base, rsp_iova, rsp_paddr, rsp_mask;
  logic [SZW-1:0] win_size;
  logic [1:0] rsp_perm;

  int n_checks = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_xlate_unit #(.ADDR_W(AW), .ENTRY_W(EW), .SHIFT_W(SW), .MAX_ENTRIES(ME)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_disable(cfg_disable),
    .cfg_base(cfg_base), .cfg_shift(cfg_shift), .cfg_count(cfg_count),
    .win_on(win_on), .win_base(win_base), .win_size(win_size),
    .tbl_clear(tbl_clear), .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_data(upd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_iova(rsp_iova),
    .rsp_paddr(rsp_paddr), .rsp_mask(rsp_mask), .rsp_perm(rsp_perm)
  );

  // Behavioural reference model, stepped on every rising edge
  logic [EW-1:0] m_mem [ME];
  logic [AW-1:0] m_base, m_iova, m_paddr, m_mask;
  logic [SW-1:0] m_shift;
  logic [CW-1:0] m_cnt;
  logic [1:0]    m_perm;
  bit m_busy, m_rv;
  int m_ptr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_base = '0; m_shift = '0; m_cnt = '0;
      m_busy = 1; m_ptr = 0; m_rv = 0;
    end else begin
      bit rdy;
      logic [AW-1:0] rel, idx, pm;
      rdy = !m_busy && (!m_rv || rsp_ready);
      if (req_valid && rdy) begin
        rel = req_addr - m_base;
        pm  = 16'hFFFF << m_shift;
        idx = rel >> m_shift;
        m_rv = 1;
        if (m_cnt != 0 && idx < AW'(m_cnt)) begin
          m_iova = rel & pm; m_paddr = m_mem[int'(idx)][AW-1:0] & pm;
          m_mask = ~pm; m_perm = m_mem[int'(idx)][1:0];
        end else begin
          m_iova = '0; m_paddr = '0; m_mask = '1; m_perm = '0;
        end
      end else if (rsp_ready) begin
        m_rv = 0;
      end
      if (m_busy) begin
        m_mem[m_ptr] = '0;
        if (m_ptr == ME - 1) begin m_busy = 0; m_ptr = 0; end
        else m_ptr++;
      end else begin
        if (upd_valid && int'(upd_idx) < ME) m_mem[int'(upd_idx)] = upd_data;
        if (tbl_clear) m_busy = 1;
      end
      if (cfg_disable) begin
        m_base = '0; m_shift = '0; m_cnt = '0;
      end else if (cfg_enable && m_cnt == 0 && cfg_count != 0) begin
        m_base = cfg_base; m_shift = cfg_shift;
        m_cnt = (int'(cfg_count) > ME) ? CW'(ME) : cfg_count;
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // Compare on the falling edge, away from the sampling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_busy) chk("R10 req_ready during sweep", 64'(req_ready), 64'(0));
      else chk("R9 req_ready", 64'(req_ready), 64'(!m_rv || rsp_ready));
      chk("R8 rsp_valid", 64'(rsp_valid), 64'(m_rv));
      if (m_rv) begin
        if (m_mask == '1) begin
          chk("R4 oob iova", 64'(rsp_iova), 64'(0));
          chk("R4 oob paddr", 64'(rsp_paddr), 64'(0));
          chk("R4 oob mask", 64'(rsp_mask), 64'(16'hFFFF));
          chk("R4 oob perm", 64'(rsp_perm), 64'(0));
        end else begin
          chk("R3 in-window", 64'(rsp_mask != 16'hFFFF), 64'(1));
          chk("R2 iova", 64'(rsp_iova), 64'(m_iova));
          chk("R2 mask", 64'(rsp_mask), 64'(m_mask));
          chk("R11 paddr from entry", 64'(rsp_paddr), 64'(m_paddr));
          chk("R1 perm", 64'(rsp_perm), 64'(m_perm));
        end
      end
      chk("R5 win_on", 64'(win_on), 64'(m_cnt != 0));
      chk("R6 win_base", 64'(win_base), 64'(m_base));
      chk("R7 win_size", 64'(win_size), 64'(SZW'(m_cnt) << m_shift));
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic open_win(logic [AW-1:0] b, logic [SW-1:0] s, logic [CW-1:0] c);
    cfg_enable = 1; cfg_base = b; cfg_shift = s; cfg_count = c;
    tick(1);
    cfg_enable = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R10: sweep after reset holds off requests; R4: window closed
    req_valid = 1; req_addr = 16'h0040;
    tick(ME + 3);
    req_valid = 0;
    // R11: fill the table, indices 12..15 must be dropped
    for (int i = 0; i < 16; i++) begin
      upd_valid = 1; upd_idx = IW'(i);
      upd_data = {$urandom, $urandom};
      upd_data[1:0] = 2'(i);
      tick(1);
    end
    upd_valid = 0;
    // R5: count 15 clamps to 12
    open_win(16'h1000, 4'd4, 4'd15);
    // R3: walk across both window edges
    for (int a = -2; a < 14; a++) begin
      req_valid = 1; req_addr = 16'(16'h1000 + a * 16 + 5);
      tick(1);
    end
    req_valid = 0;
    // R5: re-enable while open is ignored
    open_win(16'h2000, 4'd2, 4'd3);
    req_valid = 1; req_addr = 16'h10B0; tick(1);
    // R8: update on the accept edge is not seen by that request
    upd_valid = 1; upd_idx = 4'd3; upd_data = 64'h0000_0000_0000_ABC3;
    req_addr = 16'h1030; tick(1);
    upd_valid = 0; tick(1);
    // R9: random back-pressure with traffic and updates
    for (int k = 0; k < 300; k++) begin
      req_valid = 1'($urandom % 2);
      req_addr  = 16'(16'h0FF0 + ($urandom % 224));
      rsp_ready = ($urandom % 3) != 0;
      upd_valid = ($urandom % 8) == 0;
      upd_idx   = IW'($urandom % 16);
      upd_data  = {$urandom, $urandom};
      tick(1);
    end
    rsp_ready = 1; req_valid = 0; upd_valid = 0; tick(1);
    // R6: disable wins over enable in the same cycle
    cfg_disable = 1; cfg_enable = 1; tick(1);
    cfg_disable = 0; cfg_enable = 0;
    req_valid = 1; req_addr = 16'h1000; tick(1);
    // R5: enable with count 0 leaves the window closed
    open_win(16'h0100, 4'd1, 4'd0);
    tick(1);
    // R3: base near the top of the address space, shift 0
    open_win(16'hFFFE, 4'd0, 4'd5);
    for (int a = 0; a < 8; a++) begin
      req_addr = 16'(16'hFFFC + a); tick(1);
    end
    // R2: widest page, shift 15
    cfg_disable = 1; tick(1); cfg_disable = 0;
    open_win(16'h0000, 4'd15, 4'd2);
    for (int a = 0; a < 4; a++) begin
      req_addr = 16'(a * 16'h4000 + 16'h0123); tick(1);
    end
    // R10: clear, second clear and update during the sweep are ignored
    tbl_clear = 1; tick(1); tbl_clear = 0; tick(3);
    tbl_clear = 1; upd_valid = 1; upd_idx = 4'd0; upd_data = '1; tick(1);
    tbl_clear = 0; upd_valid = 0; tick(ME);
    // R1: cleared entries answer with permission 0 while in the window
    for (int a = 0; a < 4; a++) begin
      req_addr = 16'(a * 16'h4000 + 16'h0010); tick(1);
    end
    req_valid = 0; tick(3);
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule